// File: doc/BRIEF.md
# Rate-Programmable Maximal-Length Sequence Source

This block produces a 255-bit repeating pseudo-random binary stream from an 8-stage shift register. The feedback follows the primitive polynomial 1 + x^2 + x^3 + x^4 + x^8. The same module can drive a test pattern into a line-code encoder, or act as a separate noise-like interference stream. The output rate is set by a clock enable. A programmable integer divider of the system clock produces that enable, so one design can serve several symbol rates. With a 200 MHz system clock and a divide value of 20, it produces exactly 10 Mbps.

The register only moves on divider strobes. Each new bit comes with a one-cycle strobe, and a marker pulse flags the bit where the register returns to all ones. An oscilloscope or a downstream framer can trigger on that marker to lock onto the sequence. A seed can be loaded at any time, and a zero seed is replaced by all ones so that the register never stalls.

Top module: `mseq8_source`

## Requirements
- R1: When the register advances, its next state is {s[6:0], s[7]^s[5]^s[4]^s[3]}, where s[7] is the last stage. `bit_o` always shows s[7].
- R2: With `en_i` high and divide value N, the divider strobes once every N clocks. N of 0 or 1 strobes on every clock. The divider counter starts from 0 after reset, so the first strobe comes N enabled clocks after enabling. If N is lowered below the current count, the next clock strobes.
- R3: While `en_i` is low, the divider counter, the register and `bit_o` hold, and `strobe_o` stays low.
- R4: `strobe_o` is high for exactly the one clock cycle in which a newly advanced bit first appears on `bit_o`.
- R5: Between strobes and loads, `bit_o` does not change.
- R6: The register never holds the all-zero state.
- R7: A clock with `load_i` high sets the register to `seed_i`, or to 8'hFF if `seed_i` is zero. A load takes precedence over a pending advance, and it raises neither `strobe_o` nor `frame_o`.
- R8: With no loads, the marker recurs every 255 strobes.
- R9: `frame_o` is high only together with `strobe_o`, and only on the strobe where the register has just become 8'hFF.
- R10: During reset and until the synchronised release, the register is 8'hFF, the divider count is 0, `bit_o` is 1, and `strobe_o` and `frame_o` are 0.
- R11: With a divide value of 20 at a 200 MHz system clock, there are exactly 100 strobes in any 2000 consecutive enabled clocks, which is 10 Mbps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable for divider and register |
| div_i | input | DIV_W (8) | Clocks per output bit |
| load_i | input | 1 | Load `seed_i` into the register |
| seed_i | input | 8 | Seed value; zero is replaced by all ones |
| bit_o | output | 1 | Serial sequence bit (last register stage) |
| strobe_o | output | 1 | One-cycle pulse when a new bit appears |
| frame_o | output | 1 | Marker pulse when the register reaches all ones |

## Verification
The checks on loads assume that `load_i` is only raised after the internal synchronised reset has been released. A load applied while that reset is still held is dropped by the design, so the bench waits several idle clocks after releasing reset before it drives anything. The properties also assume that `en_i`, `div_i`, `load_i` and `seed_i` change only away from the rising edge. The bench drives every input on the falling edge, and it changes the divide value while enabled on purpose, to exercise the lowered-limit case.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int unsigned LFSR_W = 8;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t ALL_ONES = '1;
  // feedback taps: stages 7,5,4,3 (polynomial 1 + x^2 + x^3 + x^4 + x^8)
  localparam lfsr_t TAP_MASK = 8'b1011_1000;

  function automatic lfsr_t lfsr_step(input lfsr_t s);
    lfsr_step = {s[LFSR_W-2:0], ^(s & TAP_MASK)};
  endfunction
endpackage

// File: rtl/mseq_rst_sync.sv
module mseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mseq_rate_div.sv
module mseq_rate_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] last_cnt;

  always_comb begin
    last_cnt = (div_i == '0) ? '0 : div_i - 1'b1;
    tick_o   = en_i && (cnt_q >= last_cnt);
    cnt_d    = cnt_q;
    if (tick_o)    cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mseq_lfsr.sv
module mseq_lfsr
  import mseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  load_i,
  input  lfsr_t seed_i,
  output lfsr_t state_o,
  output logic  strobe_o,
  output logic  frame_o
);
  lfsr_t state_q, state_d;
  logic  strobe_q, strobe_d;
  logic  frame_q, frame_d;

  always_comb begin
    state_d  = state_q;
    strobe_d = 1'b0;
    frame_d  = 1'b0;
    if (load_i) begin
      state_d = (seed_i == '0) ? ALL_ONES : seed_i;
    end else if (adv_i) begin
      state_d  = lfsr_step(state_q);
      strobe_d = 1'b1;
      frame_d  = (state_d == ALL_ONES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ALL_ONES;
      strobe_q <= 1'b0;
      frame_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
      frame_q  <= frame_d;
    end
  end

  assign state_o  = state_q;
  assign strobe_o = strobe_q;
  assign frame_o  = frame_q;
endmodule

// File: rtl/mseq8_source.sv
module mseq8_source
  import mseq_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  input  logic [7:0]       seed_i,
  output logic             bit_o,
  output logic             strobe_o,
  output logic             frame_o
);
  logic  rst_sync_n;
  logic  tick;
  lfsr_t lfsr_state;

  mseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mseq_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_i   (en_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  mseq_lfsr u_lfsr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv_i    (tick),
    .load_i   (load_i),
    .seed_i   (seed_i),
    .state_o  (lfsr_state),
    .strobe_o (strobe_o),
    .frame_o  (frame_o)
  );

  assign bit_o = lfsr_state[LFSR_W-1];
endmodule

// File: rtl/mseq8_checker.sv
module mseq8_checker (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       en_i,
  input logic       load_i,
  input logic [7:0] seed_i,
  input logic [7:0] state,
  input logic       bit_o,
  input logic       strobe_o,
  input logic       frame_o
);
  a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state != 8'h00);

  a_r9_frame_needs_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_o |-> strobe_o);

  a_r9_frame_all_ones: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_o |-> state == 8'hFF);

  a_r3_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_i |=> !strobe_o);

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe_o && !$past(load_i)) |-> ($stable(state) && $stable(bit_o)));

  a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(load_i) && $past(rst_sync_n)) |->
      state == (($past(seed_i) == 8'h00) ? 8'hFF : $past(seed_i)));

  a_r7_load_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(load_i) |-> (!strobe_o && !frame_o));

  a_r1_bit_is_last_stage: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_o == state[7]);
endmodule

bind mseq8_source mseq8_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .en_i       (en_i),
  .load_i     (load_i),
  .seed_i     (seed_i),
  .state      (lfsr_state),
  .bit_o      (bit_o),
  .strobe_o   (strobe_o),
  .frame_o    (frame_o)
);

// File: tb/mseq8_source_test.sv
`timescale 1ns/1ps
module mseq8_source_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] div;
  logic       ld;
  logic [7:0] seed;
  logic       bit_o, strobe_o, frame_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state of the requirements
  logic [7:0] m_cnt, m_state;
  logic       m_strobe, m_frame;

  always #2.5 clk = ~clk;

  mseq8_source uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .div_i(div), .load_i(ld),
    .seed_i(seed), .bit_o(bit_o), .strobe_o(strobe_o), .frame_o(frame_o)
  );

  typedef struct packed {
    logic [7:0]  dv;
    logic        e;
    logic        l;
    logic [7:0]  sd;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'd3,  1'b1, 1'b0, 8'h00, 16'd30},
    '{8'd3,  1'b0, 1'b0, 8'h00, 16'd10},
    '{8'd1,  1'b1, 1'b0, 8'h00, 16'd300},
    '{8'd0,  1'b1, 1'b0, 8'h00, 16'd20},
    '{8'd1,  1'b1, 1'b1, 8'h00, 16'd1},
    '{8'd5,  1'b1, 1'b0, 8'h00, 16'd40},
    '{8'd4,  1'b0, 1'b1, 8'h5A, 16'd1},
    '{8'd2,  1'b1, 1'b0, 8'h00, 16'd40},
    '{8'd7,  1'b1, 1'b0, 8'h00, 16'd5},
    '{8'd2,  1'b1, 1'b0, 8'h00, 16'd12},
    '{8'd1,  1'b1, 1'b1, 8'hC3, 16'd3}
  };

  function automatic logic [7:0] nxt(input logic [7:0] s);
    nxt = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};   // R1
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [7:0] lim_m1;
    logic       tk;
    lim_m1 = (div == 8'd0) ? 8'd0 : div - 8'd1;
    tk = en && (m_cnt >= lim_m1);                 // R2
    if (ld) begin                                 // R7
      m_state  = (seed == 8'h00) ? 8'hFF : seed;
      m_strobe = 1'b0;
      m_frame  = 1'b0;
    end else if (tk) begin
      m_state  = nxt(m_state);
      m_strobe = 1'b1;
      m_frame  = (m_state == 8'hFF);              // R9
    end else begin
      m_strobe = 1'b0;
      m_frame  = 1'b0;
    end
    if (tk)      m_cnt = 8'd0;
    else if (en) m_cnt = m_cnt + 8'd1;           // R3 holds when idle
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R1 R5 bit_o", bit_o, m_state[7]);
    check("R2 R4 strobe_o", strobe_o, m_strobe);
    check("R9 frame_o", frame_o, m_frame);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0; en = 1'b0; div = 8'd3; ld = 1'b0; seed = 8'h00;
    m_cnt = 8'd0; m_state = 8'hFF; m_strobe = 1'b0; m_frame = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 bit_o", bit_o, 1'b1);
    check("R10 strobe_o", strobe_o, 1'b0);
    check("R10 frame_o", frame_o, 1'b0);
    rst_n = 1'b1;
    repeat (5) step();

    // vector table
    for (int v = 0; v < NV; v++) begin
      div = VEC[v].dv; en = VEC[v].e; ld = VEC[v].l; seed = VEC[v].sd;
      for (int c = 0; c < int'(VEC[v].n); c++) begin
        step();
        ld = 1'b0;
      end
    end

    // R7: zero seed gives all ones; bit_o shows 1 and no strobe
    en = 1'b0; ld = 1'b1; seed = 8'h00;
    step();
    ld = 1'b0;
    check("R7 zero seed bit_o", bit_o, 1'b1);
    check("R7 load no strobe", strobe_o, 1'b0);

    // R8: marker period of 255 strobes
    div = 8'd1; en = 1'b1;
    cnt = 0;
    while (!frame_o && cnt < 300) begin step(); cnt++; end
    cnt = 0;
    step();
    while (!frame_o && cnt < 400) begin
      if (strobe_o) cnt++;
      step();
    end
    check("R8 period 255", (cnt + 1) == 255, 1'b1);
    if ((cnt + 1) != 255) $display("FAIL R8 actual=%0d expected=255", cnt + 1);

    // R11: 10 Mbps at 200 MHz with divide value 20
    div = 8'd20;
    repeat (25) step();
    cnt = 0;
    for (int c = 0; c < 2000; c++) begin
      step();
      if (strobe_o) cnt++;
    end
    n_cmp++;
    if (cnt != 100) begin
      n_bad++;
      $display("FAIL R11 strobes actual=%0d expected=100", cnt);
    end

    // R3: idle holds bit and strobe
    en = 1'b0;
    repeat (30) step();

    // R6: after load of nonzero seed the stream keeps running
    ld = 1'b1; seed = 8'h01; en = 1'b1; div = 8'd1;
    step();
    ld = 1'b0;
    repeat (20) step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule